// File: doc/BRIEF.md
# Synchronous Serial Transmitter with Idle-Fill Characters

This block serialises parallel characters onto a single data line at one bit per period of the transmit clock, with no start or stop framing. Once the first character has gone out, the stream never stalls. If the host has not supplied the next character by the end of the current one, the block sends its programmed fill (SYNC) characters instead. In double mode it sends the pair in order. In single mode it repeats the first one. It keeps doing this until real data arrives.

The host writes characters through a one-word holding buffer. A clear-to-send input, active low, gates every character start. The transmitter-empty output rises when fill begins. It stays high while fill characters are sent and drops only when the host writes a new character. Character length (5 to 8 bits) and optional odd or even parity are taken from static setting inputs. Parity is also added to the fill characters.

Top module: `sync_fill_tx`

## Requirements
- R1: While reset is asserted and right after it is released, `txd` is 1 and `tx_empty` is 1.
- R2: Until the first character has been written, `txd` stays 1 and no fill character is sent, even with `cts_n` low.
- R3: A character starts only at a character boundary where `cts_n` is sampled low. A written character waits while `cts_n` is high.
- R4: Characters go out least significant bit first, one bit per clock period, with `txd` changing on the falling clock edge. The number of data bits is 5 + `char_len` (code 0 = 5 bits, 3 = 8 bits).
- R5: A character that is already held when the previous one ends starts in the very next clock period, with no idle bit between them.
- R6: When `par_en` is 1, one parity bit follows the data bits of every character, fill characters included. With `par_even` = 1 the total count of ones in data plus parity is even. With `par_even` = 0 it is odd.
- R7: On underrun after the first character, `dual_sync` = 1 sends `sync_a` and then `sync_b`. `dual_sync` = 0 sends `sync_a` alone. Fill repeats for as long as no data is held.
- R8: In double mode, once `sync_a` has started as fill, `sync_b` always follows it before any written character is sent.
- R9: `tx_empty` rises in the clock period in which a fill character begins and stays high through fill. It falls in the period after a write, and only on a write, including a write that arrives in the middle of fill.
- R10: If `cts_n` goes high during a character, that character completes, then `txd` holds 1 and no fill is started until `cts_n` is low again.
- R11: A write while a character is still held replaces it, so only the latest held character is sent.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_txc | input | 1 | Transmit clock; all state updates on its falling edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| cts_n | input | 1 | Clear to send, active low |
| wr_en | input | 1 | Write strobe for the holding buffer |
| wr_data | input | DATA_W | Character to transmit |
| sync_a | input | DATA_W | First fill character |
| sync_b | input | DATA_W | Second fill character (double mode) |
| dual_sync | input | 1 | 1 = fill with the pair, 0 = fill with `sync_a` only |
| char_len | input | 2 | Data bits per character minus 5 |
| par_en | input | 1 | 1 = append a parity bit |
| par_even | input | 1 | 1 = even parity, 0 = odd |
| txd | output | 1 | Serial data line, high when idle |
| tx_empty | output | 1 | High from fill start until the next write |

## Verification
The bench builds the block with the default `DATA_W` of 8, so every `char_len` code from 5 to 8 bits is in reach. Parity can then land on the ninth frame position. Directed scenarios place writes at exact clock periods: before clear-to-send, inside a `sync_a` fill, back to back into a held slot, and across a clear-to-send pause. Each expected bit stream is assembled from character values, lengths and parity rules, and compared bit by bit against the line.

// File: rtl/sfill_pkg.sv
package sfill_pkg;

  // Which character the sequencer hands to the shifter at a boundary.
  typedef enum logic [1:0] {
    SRC_NONE   = 2'd0,
    SRC_DATA   = 2'd1,
    SRC_SYNC_A = 2'd2,
    SRC_SYNC_B = 2'd3
  } src_e;

endpackage

// File: rtl/sft_hold.sv
// One-word holding buffer between the host write port and the shifter.
module sft_hold #(
  parameter int DATA_W = 8
) (
  input  logic              clk_txc,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              take,
  output logic              full,
  output logic [DATA_W-1:0] data
);

  logic              full_d, full_q;
  logic              data_en;
  logic [DATA_W-1:0] data_q;

  // A write always wins over a simultaneous take: the new word stays held.
  always_comb begin
    full_d  = full_q;
    data_en = wr_en;
    if (wr_en)     full_d = 1'b1;
    else if (take) full_d = 1'b0;
  end

  always_ff @(negedge clk_txc or negedge rst_n) begin
    if (!rst_n) full_q <= 1'b0;
    else        full_q <= full_d;
  end

  always_ff @(negedge clk_txc or negedge rst_n) begin
    if (!rst_n)       data_q <= '0;
    else if (data_en) data_q <= wr_data;
  end

  assign full = full_q;
  assign data = data_q;

endmodule

// File: rtl/sft_sequencer.sv
// Chooses the next character at each boundary and owns the empty flag.
module sft_sequencer
  import sfill_pkg::*;
(
  input  logic clk_txc,
  input  logic rst_n,
  input  logic cts_n,
  input  logic wr_en,
  input  logic dual_sync,
  input  logic at_bound,
  input  logic hold_full,
  output src_e src,
  output logic load_go,
  output logic take,
  output logic tx_empty
);

  logic started_q, started_d;
  logic pend_b_q, pend_b_d;
  logic empty_q, empty_d;

  // Priority at a boundary: unfinished SYNC pair, then held data, then fill.
  always_comb begin
    src = SRC_NONE;
    if (at_bound && !cts_n) begin
      if (pend_b_q)       src = SRC_SYNC_B;
      else if (hold_full) src = SRC_DATA;
      else if (started_q) src = SRC_SYNC_A;
    end
  end

  always_comb begin
    load_go   = (src != SRC_NONE);
    take      = (src == SRC_DATA);
    started_d = started_q | take;

    pend_b_d = pend_b_q;
    if (src == SRC_SYNC_A)      pend_b_d = dual_sync;
    else if (src == SRC_SYNC_B) pend_b_d = 1'b0;

    empty_d = empty_q;
    if (wr_en)                  empty_d = 1'b0;
    else if (src == SRC_SYNC_A) empty_d = 1'b1;
  end

  always_ff @(negedge clk_txc or negedge rst_n) begin
    if (!rst_n) begin
      started_q <= 1'b0;
      pend_b_q  <= 1'b0;
      empty_q   <= 1'b1;
    end else begin
      started_q <= started_d;
      pend_b_q  <= pend_b_d;
      empty_q   <= empty_d;
    end
  end

  assign tx_empty = empty_q;

endmodule

// File: rtl/sft_framer.sv
// Masks a character to its length and appends the parity bit.
module sft_framer #(
  parameter int DATA_W = 8,
  parameter int FRM_W  = DATA_W + 1,
  parameter int CNT_W  = $clog2(FRM_W + 1)
) (
  input  logic [DATA_W-1:0] ch,
  input  logic [1:0]        char_len,
  input  logic              par_en,
  input  logic              par_even,
  output logic [FRM_W-1:0]  frame,
  output logic [CNT_W-1:0]  flen
);

  localparam int MIN_LEN = DATA_W - 3;

  logic [CNT_W-1:0]  cb;
  logic [DATA_W-1:0] masked;
  logic [FRM_W-1:0]  ext;
  logic              par;

  assign cb = CNT_W'(MIN_LEN) + CNT_W'(char_len);

  for (genvar i = 0; i < DATA_W; i++) begin : g_mask
    assign masked[i] = (CNT_W'(i) < cb) ? ch[i] : 1'b0;
  end

  assign par = (^masked) ^ ~par_even;
  assign ext = {{(FRM_W-DATA_W){1'b0}}, masked};

  for (genvar i = 0; i < FRM_W; i++) begin : g_frame
    assign frame[i] = (par_en && (CNT_W'(i) == cb)) ? par : ext[i];
  end

  assign flen = cb + CNT_W'(par_en);

endmodule

// File: rtl/sft_shifter.sv
// Serialiser: one bit per falling edge, idles high between loads.
module sft_shifter #(
  parameter int FRM_W = 9,
  parameter int CNT_W = $clog2(FRM_W + 1)
) (
  input  logic             clk_txc,
  input  logic             rst_n,
  input  logic             load_go,
  input  logic [FRM_W-1:0] frame,
  input  logic [CNT_W-1:0] flen,
  output logic             at_bound,
  output logic             txd
);

  logic [FRM_W-1:0] frm_q, frm_d;
  logic [CNT_W-1:0] left_q, left_d;
  logic             txd_q, txd_d;
  logic             frm_en;

  // left_q counts bits still owed including the one on the line.
  assign at_bound = (left_q <= CNT_W'(1));

  always_comb begin
    frm_en = 1'b1;
    if (at_bound) begin
      if (load_go) begin
        txd_d  = frame[0];
        frm_d  = frame >> 1;
        left_d = flen;
      end else begin
        txd_d  = 1'b1;
        frm_d  = frm_q;
        frm_en = 1'b0;
        left_d = '0;
      end
    end else begin
      txd_d  = frm_q[0];
      frm_d  = frm_q >> 1;
      left_d = left_q - CNT_W'(1);
    end
  end

  always_ff @(negedge clk_txc or negedge rst_n) begin
    if (!rst_n) begin
      txd_q  <= 1'b1;
      left_q <= '0;
    end else begin
      txd_q  <= txd_d;
      left_q <= left_d;
    end
  end

  always_ff @(negedge clk_txc or negedge rst_n) begin
    if (!rst_n)      frm_q <= '0;
    else if (frm_en) frm_q <= frm_d;
  end

  assign txd = txd_q;

endmodule

// File: rtl/sync_fill_tx.sv
module sync_fill_tx
  import sfill_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk_txc,
  input  logic              rst_n,
  input  logic              cts_n,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [DATA_W-1:0] sync_a,
  input  logic [DATA_W-1:0] sync_b,
  input  logic              dual_sync,
  input  logic [1:0]        char_len,
  input  logic              par_en,
  input  logic              par_even,
  output logic              txd,
  output logic              tx_empty
);

  localparam int FRM_W = DATA_W + 1;
  localparam int CNT_W = $clog2(FRM_W + 1);

  src_e              src;
  logic              load_go;
  logic              take;
  logic              at_bound;
  logic              hold_full;
  logic [DATA_W-1:0] hold_data;
  logic [DATA_W-1:0] ch;
  logic [FRM_W-1:0]  frame;
  logic [CNT_W-1:0]  flen;

  sft_hold #(.DATA_W(DATA_W)) u_hold (
    .clk_txc (clk_txc),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .wr_data (wr_data),
    .take    (take),
    .full    (hold_full),
    .data    (hold_data)
  );

  sft_sequencer u_seq (
    .clk_txc   (clk_txc),
    .rst_n     (rst_n),
    .cts_n     (cts_n),
    .wr_en     (wr_en),
    .dual_sync (dual_sync),
    .at_bound  (at_bound),
    .hold_full (hold_full),
    .src       (src),
    .load_go   (load_go),
    .take      (take),
    .tx_empty  (tx_empty)
  );

  always_comb begin
    case (src)
      SRC_DATA:   ch = hold_data;
      SRC_SYNC_B: ch = sync_b;
      default:    ch = sync_a;
    endcase
  end

  sft_framer #(.DATA_W(DATA_W), .FRM_W(FRM_W), .CNT_W(CNT_W)) u_frm (
    .ch       (ch),
    .char_len (char_len),
    .par_en   (par_en),
    .par_even (par_even),
    .frame    (frame),
    .flen     (flen)
  );

  sft_shifter #(.FRM_W(FRM_W), .CNT_W(CNT_W)) u_shf (
    .clk_txc  (clk_txc),
    .rst_n    (rst_n),
    .load_go  (load_go),
    .frame    (frame),
    .flen     (flen),
    .at_bound (at_bound),
    .txd      (txd)
  );

endmodule

// File: rtl/sync_fill_tx_chk.sv
module sync_fill_tx_chk (
  input logic clk,
  input logic rst_n,
  input logic cts_n,
  input logic wr_en,
  input logic load_go,
  input logic txd,
  input logic tx_empty
);

  logic seen_wr;

  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n)     seen_wr <= 1'b0;
    else if (wr_en) seen_wr <= 1'b1;
  end

  // R1: reset leaves the line marking and the empty flag set.
  p_reset_state_r1: assert property (@(negedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (txd && tx_empty));

  // R2: nothing leaves the line before any character was ever written.
  p_idle_high_r2: assert property (@(negedge clk) disable iff (!rst_n)
    !seen_wr |-> txd);

  // R3: a character is only launched while clear-to-send is low.
  p_load_needs_cts_r3: assert property (@(negedge clk) disable iff (!rst_n)
    load_go |-> !cts_n);

  // R9: a captured write clears the empty flag one edge later.
  p_write_clears_r9: assert property (@(negedge clk) disable iff (!rst_n)
    wr_en |=> !tx_empty);

  // R9: the empty flag never falls without a write.
  p_fall_on_write_r9: assert property (@(negedge clk) disable iff (!rst_n)
    $fell(tx_empty) |-> $past(wr_en));

  // R9: the empty flag never rises on an edge that captured a write.
  p_rise_no_write_r9: assert property (@(negedge clk) disable iff (!rst_n)
    $rose(tx_empty) |-> !$past(wr_en));

endmodule

bind sync_fill_tx sync_fill_tx_chk u_chk (
  .clk      (clk_txc),
  .rst_n    (rst_n),
  .cts_n    (cts_n),
  .wr_en    (wr_en),
  .load_go  (load_go),
  .txd      (txd),
  .tx_empty (tx_empty)
);

// File: tb/sync_fill_tx_tb_top.sv
module sync_fill_tx_tb_top;

  localparam int CLK_P  = 10;
  localparam int DATA_W = 8;
  localparam int MAXC   = 128;

  logic              clk_txc;
  logic              rst_n;
  logic              cts_n;
  logic              wr_en;
  logic [DATA_W-1:0] wr_data;
  logic [DATA_W-1:0] sync_a;
  logic [DATA_W-1:0] sync_b;
  logic              dual_sync;
  logic [1:0]        char_len;
  logic              par_en;
  logic              par_even;
  logic              txd;
  logic              tx_empty;

  int n_chk = 0;
  int n_err = 0;

  logic exp_line [MAXC];
  bit   exp_on   [MAXC];

  sync_fill_tx #(.DATA_W(DATA_W)) dut_i (
    .clk_txc   (clk_txc),
    .rst_n     (rst_n),
    .cts_n     (cts_n),
    .wr_en     (wr_en),
    .wr_data   (wr_data),
    .sync_a    (sync_a),
    .sync_b    (sync_b),
    .dual_sync (dual_sync),
    .char_len  (char_len),
    .par_en    (par_en),
    .par_even  (par_even),
    .txd       (txd),
    .tx_empty  (tx_empty)
  );

  initial clk_txc = 1'b0;
  always #(CLK_P/2) clk_txc = ~clk_txc;

  task automatic chk(input string req, input string what, input int act, input int expv);
    n_chk++;
    if (act != expv) begin
      n_err++;
      $display("FAIL %s %s: got %0d expected %0d", req, what, act, expv);
    end
  endtask

  task automatic clear_exp();
    for (int i = 0; i < MAXC; i++) begin
      exp_line[i] = 1'b1;
      exp_on[i]   = 1'b0;
    end
  endtask

  // Expected frame: nb data bits LSB first, then optional parity.
  task automatic put_frame(input int start, input logic [7:0] d, input int nb,
                           input bit pe, input bit ev);
    logic [7:0] m;
    m = 8'(d & ((8'd1 << nb) - 8'd1));
    for (int i = 0; i < nb; i++) begin
      exp_line[start+i] = d[i];
      exp_on[start+i]   = 1'b1;
    end
    if (pe) begin
      exp_line[start+nb] = (^m) ^ ~ev;
      exp_on[start+nb]   = 1'b1;
    end
  endtask

  task automatic mark_high(input int from, input int upto);
    for (int i = from; i <= upto; i++) begin
      exp_line[i] = 1'b1;
      exp_on[i]   = 1'b1;
    end
  endtask

  task automatic line_chk(input int c, input string req);
    if (exp_on[c]) chk(req, $sformatf("txd cycle %0d", c), int'(txd), int'(exp_line[c]));
  endtask

  // Cycle c begins just after a rising edge; inputs set here are taken
  // by the following falling edge, outputs seen here come from the one before.
  task automatic next_cycle();
    @(posedge clk_txc);
    #1;
  endtask

  task automatic do_reset();
    rst_n     = 1'b0;
    cts_n     = 1'b1;
    wr_en     = 1'b0;
    wr_data   = '0;
    repeat (3) @(posedge clk_txc);
    #1;
    chk("R1", "txd in reset", int'(txd), 1);
    chk("R1", "tx_empty in reset", int'(tx_empty), 1);
    rst_n = 1'b1;
    clear_exp();
  endtask

  task automatic t_reset_idle();
    sync_a = 8'h16; sync_b = 8'h96; dual_sync = 1'b1;
    char_len = 2'd3; par_en = 1'b0; par_even = 1'b0;
    do_reset();
    chk("R1", "txd after release", int'(txd), 1);
    chk("R1", "tx_empty after release", int'(tx_empty), 1);
    mark_high(0, 19);
    for (int c = 0; c < 20; c++) begin
      next_cycle();
      if (c == 0) cts_n = 1'b0;
      line_chk(c, "R2");
    end
    chk("R2", "tx_empty while never written", int'(tx_empty), 1);
  endtask

  // 8-bit, no parity, double fill; start gated by clear-to-send.
  task automatic t_start_fill_dual();
    sync_a = 8'h16; sync_b = 8'h96; dual_sync = 1'b1;
    char_len = 2'd3; par_en = 1'b0; par_even = 1'b0;
    do_reset();
    mark_high(0, 9);
    put_frame(10, 8'hA5, 8, 0, 0);
    put_frame(18, 8'h3C, 8, 0, 0);
    put_frame(26, 8'h16, 8, 0, 0);
    put_frame(34, 8'h96, 8, 0, 0);
    put_frame(42, 8'hE1, 8, 0, 0);
    put_frame(50, 8'h16, 8, 0, 0);
    for (int c = 0; c < 58; c++) begin
      next_cycle();
      if (c <= 9)       line_chk(c, "R3");
      else if (c < 26)  line_chk(c, "R5");
      else if (c < 42)  line_chk(c, "R8");
      else              line_chk(c, "R7");
      if (c == 1)  chk("R9", "tx_empty after first write", int'(tx_empty), 0);
      if (c == 20) chk("R9", "tx_empty during data", int'(tx_empty), 0);
      if (c == 26) chk("R9", "tx_empty at fill start", int'(tx_empty), 1);
      if (c == 28) chk("R9", "tx_empty during fill", int'(tx_empty), 1);
      if (c == 29) chk("R9", "tx_empty after write in fill", int'(tx_empty), 0);
      if (c == 40) chk("R9", "tx_empty on sync_b", int'(tx_empty), 0);
      if (c == 50) chk("R9", "tx_empty refill", int'(tx_empty), 1);
      case (c)
        0:  begin wr_en = 1'b1; wr_data = 8'hA5; end
        1:  wr_en = 1'b0;
        9:  cts_n = 1'b0;
        11: begin wr_en = 1'b1; wr_data = 8'h3C; end
        12: wr_en = 1'b0;
        28: begin wr_en = 1'b1; wr_data = 8'hE1; end
        29: wr_en = 1'b0;
        default: ;
      endcase
    end
  endtask

  // 5-bit, odd parity, single fill.
  task automatic t_single_parity();
    sync_a = 8'h16; sync_b = 8'h96; dual_sync = 1'b0;
    char_len = 2'd0; par_en = 1'b1; par_even = 1'b0;
    do_reset();
    put_frame(2,  8'h0B, 5, 1, 0);
    put_frame(8,  8'h16, 5, 1, 0);
    put_frame(14, 8'h16, 5, 1, 0);
    put_frame(20, 8'h1C, 5, 1, 0);
    put_frame(26, 8'h16, 5, 1, 0);
    for (int c = 0; c < 32; c++) begin
      next_cycle();
      if ((c % 6) == 1) line_chk(c, "R6");
      else if (c < 8)   line_chk(c, "R4");
      else              line_chk(c, "R7");
      if (c == 0)  chk("R9", "tx_empty before write", int'(tx_empty), 1);
      if (c == 1)  chk("R9", "tx_empty after write", int'(tx_empty), 0);
      if (c == 8)  chk("R9", "tx_empty single fill", int'(tx_empty), 1);
      if (c == 15) chk("R9", "tx_empty second fill", int'(tx_empty), 1);
      if (c == 17) chk("R9", "tx_empty write in fill", int'(tx_empty), 0);
      if (c == 26) chk("R9", "tx_empty refill", int'(tx_empty), 1);
      case (c)
        0:  begin cts_n = 1'b0; wr_en = 1'b1; wr_data = 8'h0B; end
        1:  wr_en = 1'b0;
        16: begin wr_en = 1'b1; wr_data = 8'h1C; end
        17: wr_en = 1'b0;
        default: ;
      endcase
    end
  endtask

  // 7-bit, even parity, double fill; clear-to-send drops mid-character.
  task automatic t_pause();
    sync_a = 8'h16; sync_b = 8'h4B; dual_sync = 1'b1;
    char_len = 2'd2; par_en = 1'b1; par_even = 1'b1;
    do_reset();
    put_frame(2,  8'h55, 7, 1, 1);
    mark_high(10, 19);
    put_frame(20, 8'h2A, 7, 1, 1);
    put_frame(28, 8'h16, 7, 1, 1);
    put_frame(36, 8'h4B, 7, 1, 1);
    for (int c = 0; c < 44; c++) begin
      next_cycle();
      if (c < 28 && c >= 2) line_chk(c, "R10");
      else                  line_chk(c, "R6");
      if (c == 15) chk("R10", "tx_empty during pause", int'(tx_empty), 0);
      if (c == 28) chk("R9", "tx_empty at fill", int'(tx_empty), 1);
      case (c)
        0:  begin cts_n = 1'b0; wr_en = 1'b1; wr_data = 8'h55; end
        1:  wr_en = 1'b0;
        3:  begin wr_en = 1'b1; wr_data = 8'h2A; end
        4:  begin wr_en = 1'b0; cts_n = 1'b1; end
        19: cts_n = 1'b0;
        default: ;
      endcase
    end
  endtask

  // Back-to-back writes into a full holding slot.
  task automatic t_overwrite();
    sync_a = 8'h16; sync_b = 8'h96; dual_sync = 1'b1;
    char_len = 2'd3; par_en = 1'b0; par_even = 1'b0;
    do_reset();
    put_frame(2,  8'h11, 8, 0, 0);
    put_frame(10, 8'h33, 8, 0, 0);
    put_frame(18, 8'h16, 8, 0, 0);
    for (int c = 0; c < 22; c++) begin
      next_cycle();
      line_chk(c, "R11");
      case (c)
        0: begin cts_n = 1'b0; wr_en = 1'b1; wr_data = 8'h11; end
        1: wr_data = 8'h22;
        2: wr_data = 8'h33;
        3: wr_en = 1'b0;
        default: ;
      endcase
    end
  endtask

  initial begin
    #(CLK_P * 50000);
    n_chk++;
    n_err++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    rst_n = 1'b0; cts_n = 1'b1; wr_en = 1'b0; wr_data = '0;
    sync_a = '0; sync_b = '0; dual_sync = 1'b0;
    char_len = '0; par_en = 1'b0; par_even = 1'b0;
    t_reset_idle();
    t_start_fill_dual();
    t_single_parity();
    t_pause();
    t_overwrite();
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

endmodule